// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Completion

This block gathers level-sensitive interrupt requests from a parameterised set of sources and presents them to a few processor contexts. Each source has a small priority value. Each context has its own enable mask over the sources and its own priority threshold. A context's interrupt line is high whenever some source is latched as pending, is enabled for that context, and has a priority strictly above that context's threshold.

Software services an interrupt in two steps through one per-context register. A read of that register returns the identifier of the best eligible source, removes the source from the pending set and holds it claimed. A later write of the same identifier to the same register releases it. While a source is claimed its request line is not sampled, so a level that stays high cannot raise a second interrupt during service. It is latched again once the release has taken effect. Identifier 0 never names a source: a read that returns 0 means nothing is eligible.

All registers sit behind a single-beat 32-bit read/write port. Reads are combinational from the registered state, and their side effects take place at the clock edge that ends the access.

Top module: `irq_hub`

## Requirements
- R1: After reset every priority, enable bit and threshold reads 0, every context's interrupt output is low and every claim read returns 0.
- R2: The priority of source n sits at byte offset 4*n and is 3 bits wide. The upper bits read 0. Writes to ID 0, and reads of it, give 0. Offsets of nonexistent IDs read 0.
- R3: Enables for context c start at byte offset 0x2000 + 0x80*c. Source n is word n/32, bit n%32 (word w at +4*w). The bit for ID 0 and bits of nonexistent IDs read 0. Each context's mask is independent.
- R4: The threshold of context c is at byte offset 0x200000 + 0x1000*c. It is 3 bits wide and the upper bits read 0.
- R5: A source is eligible for a context only if it is pending, enabled there and has priority strictly greater than the threshold. A priority equal to the threshold never interrupts. The context's interrupt output follows eligibility combinationally from the registered state.
- R6: A claim read returns the eligible source with the highest priority, and the lowest ID among equal priorities.
- R7: The claim register of context c is at byte offset 0x200004 + 0x1000*c. A read of it returns the chosen ID, or 0 if none, and clears that source's pending bit. A request held high for only one clock stays pending until it is claimed.
- R8: A claimed source is not re-latched while its request stays high. After a valid completion it is latched again at the following clock edge if the level is still high.
- R9: A completion write is ignored if the ID is 0, out of range, not currently claimed, or not enabled for the context being written.
- R10: A context's interrupt output drops once its last eligible source has been claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NSRC | Level request per source ID (bit 0 unused) |
| wrEn | input | 1 | Write strobe, single beat |
| rdEn | input | 1 | Read strobe, single beat (claim side effect) |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational during the access |
| irq | output | NCTX | Interrupt request per context |

## Verification
A wrong pending or claimed bit shows up one read later. A claim returns an ID that should still be masked, or 0 where a source should have been latched again, and the interrupt line stays high or low against the bench's own eligibility arithmetic in the same cycle. A fault in selection shows at once as a wrong claimed ID. The bench sweeps many priority and threshold patterns and derives each expected ID arithmetically. It then drains all sources at equal priority, which exposes the tie-break order. A wrong register decode shows as a wrong read-back value in the address sweeps.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
  // register kind selected by the address decoder
  typedef enum logic [2:0] {
    RK_NONE  = 3'd0,
    RK_PRIO  = 3'd1,
    RK_EN    = 3'd2,
    RK_THR   = 3'd3,
    RK_CLAIM = 3'd4
  } regKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     rdStb;
    logic     wrStb;
    regKind_t kind;
  } strobe_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irqhub_pkg::*;
#(
  parameter int NSRC   = 40,
  parameter int NCTX   = 2,
  parameter int ADDR_W = 26,
  localparam int SI_W  = $clog2(NSRC),
  localparam int NWORDS = (NSRC + 31) / 32,
  localparam int WW_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int CI_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output logic [CI_W-1:0]   ctxSel,
  output logic [SI_W-1:0]   srcSel,
  output logic [WW_W-1:0]   wordSel
);
  localparam logic [ADDR_W-1:0] PRI_HI = ADDR_W'(4 * NSRC);
  localparam logic [ADDR_W-1:0] ENB_LO = ADDR_W'(32'h2000);
  localparam logic [ADDR_W-1:0] ENB_HI = ADDR_W'(32'h2000 + NCTX * 32'h80);
  localparam logic [ADDR_W-1:0] CTL_LO = ADDR_W'(32'h20_0000);
  localparam logic [ADDR_W-1:0] CTL_HI = ADDR_W'(32'h20_0000 + NCTX * 32'h1000);

  logic [ADDR_W-1:0] encOff, ctlOff;

  always_comb begin
    encOff    = addr - ENB_LO;
    ctlOff    = addr - CTL_LO;
    stb.rdStb = rdEn;
    stb.wrStb = wrEn;
    stb.kind  = RK_NONE;
    ctxSel    = '0;
    srcSel    = '0;
    wordSel   = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr < PRI_HI) begin
        stb.kind = RK_PRIO;
        srcSel   = addr[SI_W+1:2];
      end else if (addr >= ENB_LO && addr < ENB_HI && encOff[6:2] < 5'(NWORDS)) begin
        stb.kind = RK_EN;
        ctxSel   = CI_W'(encOff >> 7);
        wordSel  = encOff[WW_W+1:2];
      end else if (addr >= CTL_LO && addr < CTL_HI) begin
        ctxSel = CI_W'(ctlOff >> 12);
        if (ctlOff[11:0] == 12'h000) stb.kind = RK_THR;
        else if (ctlOff[11:0] == 12'h004) stb.kind = RK_CLAIM;
      end
    end
  end
endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irqhub_pkg::*;
#(
  parameter int NSRC   = 40,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  localparam int SI_W  = $clog2(NSRC),
  localparam int NWORDS = (NSRC + 31) / 32,
  localparam int WW_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int CI_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  strobe_t         stb,
  input  logic [CI_W-1:0] ctxSel,
  input  logic [SI_W-1:0] srcSel,
  input  logic [WW_W-1:0] wordSel,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [NCTX-1:0] irq
);
  logic [PRIO_W-1:0] prio [NSRC];
  logic [NSRC-1:0]   en   [NCTX];
  logic [PRIO_W-1:0] thr  [NCTX];
  logic [NSRC-1:0]   pend, busy, pendNext, busyNext;
  logic [NCTX-1:0][SI_W-1:0] best;

  // per-context selection: strictly above threshold, highest priority, lowest ID on ties
  for (genvar c = 0; c < NCTX; c++) begin : g_sel
    logic [SI_W-1:0]   selId;
    logic [PRIO_W-1:0] selPrio;
    always_comb begin
      selId   = '0;
      selPrio = '0;
      for (int s = 1; s < NSRC; s++) begin
        if (pend[s] && en[c][s] && prio[s] > thr[c] && prio[s] > selPrio) begin
          selPrio = prio[s];
          selId   = SI_W'(s);
        end
      end
    end
    assign best[c] = selId;
    assign irq[c]  = (selId != '0);

    // R5
    eligible_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> (prio[best[c]] > thr[c] && pend[best[c]] && en[c][best[c]]));
  end

  logic            claimDo, complDo, complOk;
  logic [SI_W-1:0] claimId, complId;

  assign claimId = best[ctxSel];
  assign claimDo = stb.rdStb && stb.kind == RK_CLAIM && claimId != '0;
  assign complId = wdata[SI_W-1:0];
  assign complOk = wdata != 32'd0 && wdata < 32'(NSRC);
  assign complDo = stb.wrStb && stb.kind == RK_CLAIM && complOk &&
                   busy[complId] && en[ctxSel][complId];

  always_comb begin
    pendNext = pend | (req & ~busy);
    busyNext = busy;
    if (claimDo) begin
      pendNext[claimId] = 1'b0;
      busyNext[claimId] = 1'b1;
    end
    if (complDo) busyNext[complId] = 1'b0;
    pendNext[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      busy <= '0;
      for (int s = 0; s < NSRC; s++) prio[s] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
    end else begin
      pend <= pendNext;
      busy <= busyNext;
      if (stb.wrStb) begin
        if (stb.kind == RK_PRIO && srcSel != '0) prio[srcSel] <= wdata[PRIO_W-1:0];
        if (stb.kind == RK_THR) thr[ctxSel] <= wdata[PRIO_W-1:0];
        if (stb.kind == RK_EN) begin
          for (int s = 1; s < NSRC; s++)
            if ((s >> 5) == int'(wordSel)) en[ctxSel][s] <= wdata[s & 31];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (stb.kind)
      RK_PRIO:  rdata = 32'(prio[srcSel]);
      RK_EN:    for (int s = 0; s < NSRC; s++)
                  if ((s >> 5) == int'(wordSel)) rdata[s & 31] = en[ctxSel][s];
      RK_THR:   rdata = 32'(thr[ctxSel]);
      RK_CLAIM: rdata = 32'(claimId);
      default:  rdata = '0;
    endcase
  end

  // R8
  pend_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & busy) == '0);
  // R7
  claim_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claimDo |=> (busy[$past(claimId)] && !pend[$past(claimId)]));
  // R9
  bad_compl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrStb && stb.kind == RK_CLAIM && !complOk && !claimDo) |=> busy == $past(busy));
  // R1
  no_source_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0] && !busy[0]);
  // R10
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (irq == '0));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irqhub_pkg::*;
#(
  parameter int NSRC   = 40,
  parameter int NCTX   = 2,
  parameter int ADDR_W = 26,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCTX-1:0]   irq
);
  localparam int SI_W   = $clog2(NSRC);
  localparam int NWORDS = (NSRC + 31) / 32;
  localparam int WW_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int CI_W   = (NCTX > 1) ? $clog2(NCTX) : 1;

  strobe_t         stb;
  logic [CI_W-1:0] ctxSel;
  logic [SI_W-1:0] srcSel;
  logic [WW_W-1:0] wordSel;

  irq_hub_ctrl #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) u_ctrl (
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .stb(stb), .ctxSel(ctxSel), .srcSel(srcSel), .wordSel(wordSel)
  );

  irq_hub_dp #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .req(req), .stb(stb),
    .ctxSel(ctxSel), .srcSel(srcSel), .wordSel(wordSel),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );
endmodule

// File: tb/tb_irq_hub.sv
`timescale 1ns/1ps
module tb_irq_hub;
  localparam int NSRC = 40;
  localparam int NCTX = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] req = '0;
  logic            wrEn = 1'b0, rdEn = 1'b0;
  logic [25:0]     addr = '0;
  logic [31:0]     wdata = '0, rdata;
  logic [NCTX-1:0] irq;

  int checks = 0, fails = 0;
  int pv [8];

  always #2.5 clk = ~clk;

  irq_hub dut (.clk(clk), .rst_n(rst_n), .req(req), .wrEn(wrEn), .rdEn(rdEn),
               .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic int prA(int id); return 4 * id; endfunction
  function automatic int enA(int c, int w); return 32'h2000 + 32'h80 * c + 4 * w; endfunction
  function automatic int thA(int c); return 32'h20_0000 + 32'h1000 * c; endfunction
  function automatic int clA(int c); return 32'h20_0004 + 32'h1000 * c; endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = 26'(a); wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = 26'(a);
    #1 d = rdata;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected selection among IDs 1..7 in mask, priority strictly above th
  function automatic int bestOf(int mask, int th);
    int b = 0, bp = 0;
    for (int s = 1; s < 8; s++)
      if (mask[s] && pv[s] > th && pv[s] > bp) begin bp = pv[s]; b = s; end
    return b;
  endfunction

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int rem, th, e;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd(clA(0), v); chk("R1 claim0", v, 0);
    rd(clA(1), v); chk("R1 claim1", v, 0);
    rd(prA(5), v); chk("R1 prio", v, 0);
    rd(enA(1, 1), v); chk("R1 enable", v, 0);
    rd(thA(0), v); chk("R1 thr", v, 0);

    // R2 priority map sweep
    for (int id = 0; id < NSRC; id++) wr(prA(id), 32'hFFFF_FFF0 | 32'(id));
    for (int id = 0; id < NSRC; id++) begin
      rd(prA(id), v); chk("R2 prio readback", v, (id == 0) ? 0 : 32'(id % 8));
    end
    rd(prA(NSRC), v); chk("R2 out of range", v, 0);

    // R3 enable map
    wr(enA(0, 0), 32'hFFFF_FFFF);
    wr(enA(0, 1), 32'hFFFF_FFFF);
    rd(enA(0, 0), v); chk("R3 word0 id0 zero", v, 32'hFFFF_FFFE);
    rd(enA(0, 1), v); chk("R3 word1 upper zero", v, 32'h0000_00FF);
    rd(enA(1, 0), v); chk("R3 ctx1 independent", v, 0);
    wr(enA(0, 1), 0);
    wr(enA(0, 0), 32'h0000_00FE);

    // R4 threshold
    wr(thA(1), 32'hFFFF_FFFD);
    rd(thA(1), v); chk("R4 thr width", v, 5);
    rd(thA(0), v); chk("R4 thr ctx0 untouched", v, 0);
    wr(thA(1), 0);

    // R5 R6 R10 sweep over priority and threshold patterns on IDs 1..7
    for (int t = 0; t < 16; t++) begin
      for (int s = 1; s < 8; s++) begin
        pv[s] = (s * (t + 3) + t) % 8;
        wr(prA(s), 32'(pv[s]));
      end
      th = t % 4;
      wr(thA(0), 32'(th));
      @(negedge clk); req[7:1] = 7'h7F;
      idle(1);
      rem = 32'hFE;
      for (int k = 0; k < 8; k++) begin
        e = bestOf(rem, th);
        chk("R5 irq follows eligibility", 32'(irq[0]), 32'(e != 0));
        rd(clA(0), v); chk("R6 claim order", v, 32'(e));
        if (e == 0) break;
        rem[e] = 1'b0;
      end
      chk("R10 irq low after last claim", 32'(irq[0]), 0);
      // R6 equal priorities drain in ascending ID
      @(negedge clk); req = '0;
      for (int s = 1; s < 8; s++) begin pv[s] = 7; wr(prA(s), 7); end
      wr(thA(0), 0);
      for (int k = 0; k < 8; k++) begin
        e = bestOf(rem, 0);
        rd(clA(0), v); chk("R6 tie lowest ID", v, 32'(e));
        if (e == 0) break;
        rem[e] = 1'b0;
      end
      for (int s = 1; s < 8; s++) wr(clA(0), 32'(s));
      idle(1);
      rd(clA(0), v); chk("R8 nothing left", v, 0);
    end

    for (int s = 1; s < 8; s++) wr(prA(s), 0);

    // R7 R8 claim gating and re-latch
    wr(prA(3), 5);
    @(negedge clk); req[3] = 1'b1;
    idle(1);
    rd(clA(0), v); chk("R7 claim id", v, 3);
    rd(clA(0), v); chk("R8 masked while claimed", v, 0);
    chk("R10 irq low while claimed", 32'(irq[0]), 0);

    // R9 ignored completions
    wr(clA(0), 5);
    wr(clA(1), 3);
    wr(clA(0), 0);
    wr(clA(0), 63);
    idle(1);
    rd(clA(0), v); chk("R9 bad completions ignored", v, 0);

    wr(clA(0), 3);
    idle(1);
    chk("R8 relatched irq", 32'(irq[0]), 1);
    rd(clA(0), v); chk("R8 relatched claim", v, 3);
    @(negedge clk); req[3] = 1'b0;
    wr(clA(0), 3);
    idle(1);
    rd(clA(0), v); chk("R8 no relatch when low", v, 0);

    // R7 single-cycle pulse stays pending
    wr(prA(5), 2);
    @(negedge clk); req[5] = 1'b1;
    @(negedge clk); req[5] = 1'b0;
    idle(2);
    chk("R7 pulse irq", 32'(irq[0]), 1);
    rd(clA(0), v); chk("R7 pulse claim", v, 5);
    wr(clA(0), 5);
    idle(2);
    rd(clA(0), v); chk("R7 pulse not repeated", v, 0);

    // R5 strict threshold compare
    wr(prA(4), 3);
    wr(thA(0), 3);
    @(negedge clk); req[4] = 1'b1;
    idle(1);
    chk("R5 equal prio no irq", 32'(irq[0]), 0);
    rd(clA(0), v); chk("R5 equal prio no claim", v, 0);
    wr(thA(0), 2);
    chk("R5 above thr irq", 32'(irq[0]), 1);
    rd(clA(0), v); chk("R5 above thr claim", v, 4);
    @(negedge clk); req[4] = 1'b0;
    wr(clA(0), 4);

    // R3 R9 second context, second enable word
    wr(prA(33), 6);
    wr(enA(1, 1), 32'h2);
    @(negedge clk); req[33] = 1'b1;
    idle(1);
    chk("R3 ctx1 irq via word1", 32'(irq), 2);
    rd(clA(1), v); chk("R3 ctx1 claim", v, 33);
    wr(clA(0), 33);
    idle(1);
    rd(clA(1), v); chk("R9 completion from wrong ctx", v, 0);
    @(negedge clk); req[33] = 1'b0;
    wr(clA(1), 33);
    idle(1);
    chk("R10 all quiet", 32'(irq), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule